// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked host read and write an external asynchronous static RAM of 512K bytes. The host issues one access at a time over a request/ready handshake: a 19-bit address, a write flag and a write byte. A read returns its byte on a separate output, marked by a one-cycle valid strobe. On the memory side the block drives the address, active-low chip select, write enable and output enable. The bidirectional data bus is split into an outgoing byte, an incoming byte and a drive-enable, so the pad tri-state sits outside the block.

The memory has no clock, so every minimum it needs is met by holding control levels for a whole number of controller cycles. Three parameters set these counts from the clock period: the read access time, the write pulse width and the output-enable turnaround before a write. All memory-side outputs come straight from registers, so write enable cannot glitch. During a write the output enable stays high. The block's own data drivers turn on only in the write pulse, after the memory's outputs have had the turnaround time to float. The drivers turn off on the same edge that ends the pulse.

Top module: `asram_ctl`

## Requirements
- R1: While and after reset, chip select, write enable and output enable are high, the data drive-enable is low, ready is high and read-valid is low.
- R2: Ready is high only while the block is idle. A request presented while ready is low is ignored and has no effect on memory contents.
- R3: A read holds chip select and output enable low and write enable high for exactly ACCESS_CYC cycles. The byte on the data input at the end of that time is the one returned to the host.
- R4: A write holds output enable high throughout. Write enable is low only while chip select is low, and stays low for exactly PULSE_CYC cycles.
- R5: The data drive-enable is high exactly while write enable is low. It turns off on the edge that raises write enable.
- R6: The data drive-enable turns on only after output enable has been high for at least TURN_CYC cycles.
- R7: The memory address does not change while chip select stays low.
- R8: Chip select returns high between any two accesses, giving one chip-select-low period per accepted request.
- R9: The outgoing data byte does not change while the drive-enable stays high.
- R10: Read-valid is a single-cycle pulse, raised once per read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request, taken when ready is high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Byte address |
| host_wdata | input | 8 | Byte to write |
| host_rdy | output | 1 | Block idle, request will be accepted |
| host_rdata | output | 8 | Byte returned by the last read |
| host_rvalid | output | 1 | One-cycle strobe for host_rdata |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_in | input | 8 | Byte sampled from the data bus |
| mem_dq_oe | output | 1 | Drive-enable for mem_dq_out |

## Verification
The assertions check the bus protocol on every cycle: the pulse-width and access-time counts, write enable never low without chip select, output enable high during writes, the driver enable tracking write enable, the turnaround count, and stable address and data while they are in use. Two things only the scenarios can show: whether the byte returned to the host is the right one, and whether the captured byte was taken late enough. For this the bench models the memory so that it presents garbage until the access time has elapsed. The bench also shows that a request made while busy leaves memory contents untouched, including writes at both ends of the address range.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_TURN  = 2'd2,
        ST_PULSE = 2'd3
    } asram_state_e;

    // Registered memory-side control levels
    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drv;
    } mem_ctl_t;

    localparam mem_ctl_t CTL_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

    // Control levels for the state about to be entered
    function automatic mem_ctl_t ctl_for(asram_state_e s);
        mem_ctl_t c;
        c = CTL_IDLE;
        case (s)
            ST_READ:  begin c.cs_n = 1'b0; c.oe_n = 1'b0; end
            ST_TURN:  begin c.cs_n = 1'b0; end
            ST_PULSE: begin c.cs_n = 1'b0; c.we_n = 1'b0; c.drv = 1'b1; end
            default:  c = CTL_IDLE;
        endcase
        return c;
    endfunction

    function automatic int phase_cnt_w(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        m = (m > c) ? m : c;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Last cycle of the phase
    assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grab,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= grab;
            if (grab)
                dout <= din;
        end
    end
endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
    import asram_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int ACCESS_CYC = 2,
    parameter int PULSE_CYC  = 2,
    parameter int TURN_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_rdy,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int CNT_W = phase_cnt_w(ACCESS_CYC, PULSE_CYC, TURN_CYC);

    asram_state_e     state_q, state_d;
    mem_ctl_t         ctl_q;
    logic             load, done, grab;
    logic [CNT_W-1:0] load_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .done     (done)
    );

    asram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .grab  (grab),
        .din   (mem_dq_in),
        .dout  (host_rdata),
        .valid (host_rvalid)
    );

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        grab     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    load = 1'b1;
                    if (host_wr) begin
                        state_d  = ST_TURN;
                        load_val = CNT_W'(TURN_CYC);
                    end else begin
                        state_d  = ST_READ;
                        load_val = CNT_W'(ACCESS_CYC);
                    end
                end
            end
            ST_READ: begin
                if (done) begin
                    state_d = ST_IDLE;
                    grab    = 1'b1;
                end
            end
            ST_TURN: begin
                if (done) begin
                    state_d  = ST_PULSE;
                    load     = 1'b1;
                    load_val = CNT_W'(PULSE_CYC);
                end
            end
            ST_PULSE: begin
                if (done)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= CTL_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_for(state_d);
            if (state_q == ST_IDLE && host_req) begin
                addr_q <= host_addr;
                data_q <= host_wdata;
            end
        end
    end

    assign host_rdy   = (state_q == ST_IDLE);
    assign mem_addr   = addr_q;
    assign mem_dq_out = data_q;
    assign mem_cs_n   = ctl_q.cs_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_dq_oe  = ctl_q.drv;
endmodule

// File: rtl/asram_ctl_checker.sv
module asram_ctl_checker #(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int ACCESS_CYC = 2,
    parameter int PULSE_CYC  = 2,
    parameter int TURN_CYC   = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              host_rdy,
    input logic              host_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    logic        rst_d;
    logic [15:0] we_lo_cnt, oe_lo_cnt, oe_hi_cnt;

    always_ff @(posedge clk) begin
        rst_d     <= rst;
        we_lo_cnt <= mem_we_n ? 16'd0 : we_lo_cnt + 16'd1;
        oe_lo_cnt <= mem_oe_n ? 16'd0 : oe_lo_cnt + 16'd1;
        if (!mem_oe_n)
            oe_hi_cnt <= 16'd0;
        else if (oe_hi_cnt != 16'hFFFF)
            oe_hi_cnt <= oe_hi_cnt + 16'd1;
    end

    always @(posedge clk) begin
        if (rst_d === 1'b1)
            AST_RESET_LEVELS: assert (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe
                                      && host_rdy && !host_rvalid); // R1
    end

    AST_RDY_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        host_rdy |-> mem_cs_n); // R8
    AST_READ_ACCESS_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (oe_lo_cnt == 16'(ACCESS_CYC))); // R3
    AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n)); // R3
    AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n)); // R4
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_lo_cnt == 16'(PULSE_CYC))); // R4
    AST_DRV_TRACKS_WE: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe == !mem_we_n); // R5
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (oe_hi_cnt >= 16'(TURN_CYC))); // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R7
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R9
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |=> !host_rvalid); // R10
endmodule

bind asram_ctl asram_ctl_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ACCESS_CYC (ACCESS_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .TURN_CYC   (TURN_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_rdy    (host_rdy),
    .host_rvalid (host_rvalid),
    .mem_addr    (mem_addr),
    .mem_cs_n    (mem_cs_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dq_out  (mem_dq_out),
    .mem_dq_oe   (mem_dq_oe)
);

// File: tb/sim_asram_ctl.sv
module sim_asram_ctl;
    localparam int AW  = 19;
    localparam int DW  = 8;
    localparam int ACC = 2;
    localparam int PUL = 2;
    localparam int TRN = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_req = 1'b0, host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_rdy, host_rvalid;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'hEE;

    int checks = 0, errors = 0, cyc = 0;
    int issued = 0, cs_falls = 0;
    logic [DW-1:0] shadow [int];
    logic [DW-1:0] devmem [int];
    logic [DW-1:0] expq [$];

    always #2.5 clk = ~clk;

    asram_ctl #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CYC(ACC), .PULSE_CYC(PUL), .TURN_CYC(TRN)) u0 (
        .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdy(host_rdy),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: waits for ready, presents one request, records expectations
    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        while (!host_rdy) @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        issued++;
        if (wr) shadow[int'(a)] = d;
        else expq.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
    endtask

    // Memory model and bus monitor, all at the falling edge
    int oe_lo = 0, oe_hi = 0, we_lo = 0;
    logic [AW-1:0] cs_addr;
    logic [DW-1:0] wr_byte;
    logic prev_cs_n = 1'b1, prev_drv = 1'b0, prev_rv = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_cs_n && prev_cs_n) begin cs_falls++; cs_addr = mem_addr; end
            if (!mem_cs_n && !prev_cs_n)
                chk(mem_addr == cs_addr, "R7 addr held", 32'(mem_addr), 32'(cs_addr));
            if (mem_dq_oe && !prev_drv)
                chk(oe_hi >= TRN, "R6 turnaround", oe_hi, TRN);
            if (!mem_we_n) begin
                if (we_lo == 0) wr_byte = mem_dq_out;
                else chk(mem_dq_out == wr_byte, "R9 data held", 32'(mem_dq_out), 32'(wr_byte));
                we_lo++;
                chk(mem_dq_oe && mem_oe_n && !mem_cs_n, "R4/R5 write levels",
                    {mem_dq_oe, mem_oe_n, mem_cs_n}, 3'b110);
            end else if (we_lo != 0) begin
                chk(we_lo == PUL, "R4 pulse width", we_lo, PUL);
                chk(!mem_dq_oe, "R5 driver released", mem_dq_oe, 0);
                devmem[int'(mem_addr)] = wr_byte;
                we_lo = 0;
            end
            oe_lo = (!mem_cs_n && !mem_oe_n) ? oe_lo + 1 : 0;
            oe_hi = mem_oe_n ? oe_hi + 1 : 0;
            mem_dq_in = (oe_lo >= ACC) ?
                (devmem.exists(int'(mem_addr)) ? devmem[int'(mem_addr)] : 8'h00) : 8'hEE;
            if (host_rvalid) begin
                chk(!prev_rv, "R10 single pulse", prev_rv, 0);
                if (expq.size() == 0) chk(1'b0, "R10 unexpected valid", 1, 0);
                else begin
                    logic [DW-1:0] e;
                    e = expq.pop_front();
                    chk(host_rdata == e, "R3 read data", 32'(host_rdata), 32'(e));
                end
            end
            prev_cs_n = mem_cs_n; prev_drv = mem_dq_oe; prev_rv = host_rvalid;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && host_rdy && !host_rvalid,
            "R1 reset levels", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, host_rdy, host_rvalid}, 6'b111010);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_cs_n && host_rdy, "R1 idle after reset", {mem_cs_n, host_rdy}, 2'b11);

        access(1, 19'h00000, 8'h5A);
        access(1, 19'h7FFFF, 8'hA5);
        access(1, 19'h12345, 8'h3C);
        access(0, 19'h00000, 0);
        access(0, 19'h7FFFF, 0);
        access(0, 19'h12345, 0);
        access(0, 19'h00100, 0);      // never written
        access(1, 19'h12345, 8'hC3);  // overwrite then read back at once
        access(0, 19'h12345, 0);
        access(1, 19'h00005, 8'h11);

        // R2: request while busy must be ignored
        @(negedge clk);
        while (!host_rdy) @(negedge clk);
        host_req = 1'b1; host_wr = 1'b0; host_addr = 19'h00005;
        issued++;
        expq.push_back(8'h11);
        @(posedge clk);
        @(negedge clk);
        chk(!host_rdy, "R2 busy not ready", host_rdy, 0);
        host_wr = 1'b1; host_wdata = 8'h99;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        access(0, 19'h00005, 0);

        // back-to-back mixed traffic
        for (int i = 0; i < 6; i++) access(1, 19'(20'h40000 + i), 8'(8'h20 + 3 * i));
        for (int i = 5; i >= 0; i--) access(0, 19'(20'h40000 + i), 0);

        repeat (10) @(negedge clk);
        chk(expq.size() == 0, "R3 all reads returned", expq.size(), 0);
        chk(cs_falls == issued, "R8 one select per access", cs_falls, issued);
        chk(host_rdy && mem_cs_n, "R2 idle at end", {host_rdy, mem_cs_n}, 2'b11);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule